// File: doc/BRIEF.md
# Byte-Wide Flash Read Bridge for a GPIO Host

This block lets a processor that has only a narrow bank of general-purpose I/O pins read single bytes from an 8-bit parallel NOR flash. The host side is made of one bidirectional data byte and four control lines: a strobe, a read/write line and two register-select lines. The bridge synchronises these lines into its own clock. Each strobe makes exactly one register access.

To read a byte, the host writes the flash address as three bytes (low, middle, high) and then writes the read command code into the control register. After that it polls the control register until the done flag is set, and then reads the captured byte from the data register. Internally, a small state machine performs the flash cycle. It drives the address, lowers chip enable, lowers output enable for a programmable number of clock cycles, captures the data, and releases the flash. Only reads are supported, so the flash write enable never leaves its inactive level.

Top module: `gfb_bridge`

## Requirements
- R1: After reset, flash_ce_n, flash_oe_n and flash_we_n are high. A read of the control register (sel 3) returns 8'h00.
- R2: A write strobe with rnw=0 stores host_data into a register chosen by sel: 0 is address bits [7:0], 1 is bits [15:8], 2 is bits [23:16]. On the next read, flash_addr carries the low ADDR_W bits of this 24-bit value, and the upper bits are discarded.
- R3: A write to sel 3 whose data equals CMD_READ (default 8'h01) starts a flash read when the bridge is idle. A write to sel 3 with any other value starts nothing and leaves the status unchanged.
- R4: During a read, flash_ce_n falls exactly one cycle before flash_oe_n. flash_oe_n then stays low for WAIT_CYC+1 cycles, and both lines rise on the same edge.
- R5: A read of sel 3 returns done in bit 0 and busy in bit 1, with the other bits zero. busy is set while a read is in progress. Starting a read clears done. done is set once the byte is captured, and done and busy are never set together.
- R6: A read command written while busy is ignored. It causes no additional flash cycle.
- R7: Address-register writes during a read do not change flash_addr for that read, and they do not change the byte it returns.
- R8: flash_we_n is high on every cycle.
- R9: The bridge drives host_data only while the synchronised strobe and rnw are both high. In that state sel 3 returns the status and any other sel returns the captured data byte. At all other times host_data is released to high impedance.
- R10: A strobe held high for many cycles makes a single register access. A held read command starts exactly one flash cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_stb | input | 1 | Host access strobe; an access takes place on its synchronised rising edge |
| host_rnw | input | 1 | 1 = host reads, 0 = host writes |
| host_sel | input | 2 | Register select |
| host_data | inout | 8 | Bidirectional host data byte |
| flash_addr | output | ADDR_W | Flash address |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low, held inactive |
| flash_dq | input | 8 | Flash data byte |

## Verification
The bound checker covers the pin-level rules on every cycle. It confirms that write enable stays high and that output enable is only low under chip enable. It also checks that chip enable leads output enable, that the output-enable window never exceeds its length, that the address is stable while the flash is selected, and that done and busy are exclusive.

Some behaviours can only be shown by the bench's directed scenarios. These are the register map and the assembly of the address from three bytes, and that unrecognised commands and commands written while busy are ignored. The same holds for the returned byte matching the flash contents, the release of the host bus, and a long strobe producing a single flash cycle.

// File: rtl/gfb_pkg.sv
`timescale 1ns/1ps
package gfb_pkg;
    typedef enum logic [2:0] {
        RD_IDLE,
        RD_SETUP,
        RD_ACCESS,
        RD_CAPTURE,
        RD_DONE
    } rd_state_e;

    localparam logic [1:0] SEL_ALO  = 2'd0;
    localparam logic [1:0] SEL_AMID = 2'd1;
    localparam logic [1:0] SEL_AHI  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    localparam int HOST_CTL_W = 4;
endpackage

// File: rtl/gfb_sync.sv
`timescale 1ns/1ps
module gfb_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
        end
        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/gfb_read_fsm.sv
`timescale 1ns/1ps
module gfb_read_fsm
    import gfb_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int WAIT_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        flash_dq_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [7:0]        data_o,
    output logic [ADDR_W-1:0] flash_addr_o,
    output logic              ce_n_o,
    output logic              oe_n_o
);
    localparam int CNT_W = $clog2(WAIT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

    typedef struct packed {
        rd_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } fsm_t;

    fsm_t d, q;

    always_comb begin
        d = q;
        unique case (q.state)
            RD_IDLE: begin
                if (start_i) begin
                    d.addr  = addr_i;
                    d.cnt   = '0;
                    d.state = RD_SETUP;
                end
            end
            RD_SETUP:  d.state = RD_ACCESS;
            RD_ACCESS: begin
                if (q.cnt == CNT_LAST) d.state = RD_CAPTURE;
                else                   d.cnt   = q.cnt + 1'b1;
            end
            RD_CAPTURE: begin
                d.data  = flash_dq_i;
                d.state = RD_DONE;
            end
            RD_DONE:   d.state = RD_IDLE;
            default:   d.state = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= RD_IDLE;
            q.cnt   <= '0;
            q.addr  <= '0;
            q.data  <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o       = (q.state != RD_IDLE);
    assign done_o       = (q.state == RD_DONE);
    assign data_o       = q.data;
    assign flash_addr_o = q.addr;
    assign ce_n_o       = !(q.state inside {RD_SETUP, RD_ACCESS, RD_CAPTURE});
    assign oe_n_o       = !(q.state inside {RD_ACCESS, RD_CAPTURE});
endmodule

// File: rtl/gfb_bridge.sv
`timescale 1ns/1ps
module gfb_bridge
    import gfb_pkg::*;
#(
    parameter int         ADDR_W   = 20,
    parameter int         WAIT_CYC = 4,
    parameter logic [7:0] CMD_READ = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_stb,
    input  logic              host_rnw,
    input  logic [1:0]        host_sel,
    inout  wire  [7:0]        host_data,
    output logic [ADDR_W-1:0] flash_addr,
    output logic              flash_ce_n,
    output logic              flash_oe_n,
    output logic              flash_we_n,
    input  logic [7:0]        flash_dq
);
    localparam int HI_BITS = ADDR_W - 16;

    typedef struct packed {
        logic [7:0] addr_lo;
        logic [7:0] addr_mid;
        logic [7:0] addr_hi;
        logic       done;
        logic       stb_prev;
    } regs_t;

    regs_t d, q;

    logic [HOST_CTL_W-1:0] ctl_s;
    logic                  stb_s, rnw_s;
    logic [1:0]            sel_s;
    logic                  wr_pulse, cmd_wr, start;
    logic                  fsm_busy, fsm_done;
    logic [7:0]            fsm_data, status, rd_val;
    logic                  drive;
    logic [ADDR_W-1:0]     addr_full;
    logic                  st_done, st_busy;

    gfb_sync #(.W(HOST_CTL_W), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({host_rnw, host_sel, host_stb}),
        .sync_o  (ctl_s)
    );

    assign stb_s = ctl_s[0];
    assign sel_s = ctl_s[2:1];
    assign rnw_s = ctl_s[3];

    assign wr_pulse  = stb_s && !q.stb_prev && !rnw_s;
    assign cmd_wr    = wr_pulse && (sel_s == SEL_CTRL) && (host_data == CMD_READ);
    assign start     = cmd_wr && !fsm_busy;
    assign addr_full = {q.addr_hi[HI_BITS-1:0], q.addr_mid, q.addr_lo};

    always_comb begin
        d = q;
        d.stb_prev = stb_s;
        if (wr_pulse) begin
            unique case (sel_s)
                SEL_ALO:  d.addr_lo  = host_data;
                SEL_AMID: d.addr_mid = host_data;
                SEL_AHI:  d.addr_hi  = host_data;
                default:  ;
            endcase
        end
        if (start)    d.done = 1'b0;
        if (fsm_done) d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.addr_lo  <= '0;
            q.addr_mid <= '0;
            q.addr_hi  <= '0;
            q.done     <= 1'b0;
            q.stb_prev <= 1'b0;
        end else begin
            q <= d;
        end
    end

    gfb_read_fsm #(.ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .addr_i       (addr_full),
        .flash_dq_i   (flash_dq),
        .busy_o       (fsm_busy),
        .done_o       (fsm_done),
        .data_o       (fsm_data),
        .flash_addr_o (flash_addr),
        .ce_n_o       (flash_ce_n),
        .oe_n_o       (flash_oe_n)
    );

    assign status     = {6'b0, fsm_busy, q.done};
    assign rd_val     = (sel_s == SEL_CTRL) ? status : fsm_data;
    assign drive      = stb_s && rnw_s;
    assign host_data  = drive ? rd_val : 8'bz;
    assign flash_we_n = 1'b1;
    assign st_done    = q.done;
    assign st_busy    = fsm_busy;
endmodule

// File: rtl/gfb_checker.sv
`timescale 1ns/1ps
module gfb_checker #(
    parameter int ADDR_W   = 20,
    parameter int WAIT_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              done,
    input logic              busy
);
    localparam int OE_MAX = WAIT_CYC + 1;

    logic [$clog2(OE_MAX + 2)-1:0] oe_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     oe_cnt_q <= '0;
        else if (!oe_n) oe_cnt_q <= (oe_cnt_q > OE_MAX) ? oe_cnt_q : oe_cnt_q + 1'b1;
        else            oe_cnt_q <= '0;
    end

    p_we_high_r8: assert property (@(posedge clk) disable iff (!rst_n) we_n);

    p_oe_under_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !ce_n);

    p_ce_leads_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> !$past(ce_n));

    p_oe_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        oe_cnt_q <= OE_MAX);

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !$past(ce_n)) |-> $stable(addr));

    p_done_busy_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));
endmodule

bind gfb_bridge gfb_checker #(.ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ce_n  (flash_ce_n),
    .oe_n  (flash_oe_n),
    .we_n  (flash_we_n),
    .addr  (flash_addr),
    .done  (st_done),
    .busy  (st_busy)
);

// File: tb/tb_gfb_bridge.sv
`timescale 1ns/1ps
module tb_gfb_bridge;
    localparam int ADDR_W = 20;
    localparam int WAIT   = 40;
    localparam logic [7:0] CMD = 8'h01;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_stb = 1'b0;
    logic              host_rnw = 1'b0;
    logic [1:0]        host_sel = 2'd0;
    wire  [7:0]        host_data;
    logic [7:0]        tb_dat = 8'h00;
    logic              tb_oe = 1'b0;
    logic [ADDR_W-1:0] flash_addr;
    logic              flash_ce_n, flash_oe_n, flash_we_n;
    logic [7:0]        flash_dq;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign host_data = tb_oe ? tb_dat : 8'bz;

    function automatic logic [7:0] mem_model(logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h3};
    endfunction

    assign flash_dq = (!flash_ce_n && !flash_oe_n) ? mem_model(flash_addr) : 8'h00;

    gfb_bridge #(.ADDR_W(ADDR_W), .WAIT_CYC(WAIT), .CMD_READ(CMD)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_stb   (host_stb),
        .host_rnw   (host_rnw),
        .host_sel   (host_sel),
        .host_data  (host_data),
        .flash_addr (flash_addr),
        .flash_ce_n (flash_ce_n),
        .flash_oe_n (flash_oe_n),
        .flash_we_n (flash_we_n),
        .flash_dq   (flash_dq)
    );

    // Pin monitor, sampled away from the active edge
    int  ce_falls = 0;
    int  ce_run = 0;
    int  oe_run = 0;
    int  last_lead = -1;
    int  last_oe_len = -1;
    bit  rise_apart = 0;
    bit  we_seen_low = 0;
    logic prev_ce = 1'b1, prev_oe = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!flash_we_n) we_seen_low = 1;
            if (!flash_ce_n && prev_ce) ce_falls++;
            if (!flash_oe_n && prev_oe) last_lead = ce_run;
            if (flash_oe_n && !prev_oe) begin
                last_oe_len = oe_run;
                if (!flash_ce_n) rise_apart = 1;
            end
            if (!flash_ce_n && flash_oe_n && !prev_oe) rise_apart = 1;
            ce_run = flash_ce_n ? 0 : ce_run + 1;
            oe_run = flash_oe_n ? 0 : oe_run + 1;
            prev_ce = flash_ce_n;
            prev_oe = flash_oe_n;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_write(logic [1:0] sel, logic [7:0] val, int hold = 6);
        @(negedge clk);
        host_rnw = 1'b0; host_sel = sel; tb_dat = val; tb_oe = 1'b1;
        @(negedge clk);
        host_stb = 1'b1;
        repeat (hold) @(negedge clk);
        host_stb = 1'b0;
        repeat (4) @(negedge clk);
        tb_oe = 1'b0;
    endtask

    task automatic host_read(logic [1:0] sel, output logic [7:0] val);
        @(negedge clk);
        tb_oe = 1'b0; host_rnw = 1'b1; host_sel = sel;
        @(negedge clk);
        host_stb = 1'b1;
        repeat (5) @(negedge clk);
        val = host_data;
        host_stb = 1'b0;
        repeat (4) @(negedge clk);
        host_rnw = 1'b0;
    endtask

    task automatic load_addr(logic [23:0] a);
        host_write(2'd0, a[7:0]);
        host_write(2'd1, a[15:8]);
        host_write(2'd2, a[23:16]);
    endtask

    task automatic poll_done(output bit ok);
        logic [7:0] s;
        ok = 0;
        for (int i = 0; i < 40; i++) begin
            host_read(2'd3, s);
            if (s[0]) begin ok = 1; break; end
        end
    endtask

    task automatic t_reset;
        logic [7:0] s;
        chk("R1 ce_n", flash_ce_n, 1);
        chk("R1 oe_n", flash_oe_n, 1);
        chk("R1 we_n", flash_we_n, 1);
        chk("R9 idle bus z", host_data, 8'bz);
        host_read(2'd3, s);
        chk("R1 status", s, 8'h00);
        chk("R9 released after read", host_data, 8'bz);
    endtask

    task automatic t_basic(logic [23:0] a);
        logic [7:0] s, v;
        bit ok;
        int f0 = ce_falls;
        load_addr(a);
        host_write(2'd3, CMD);
        chk("R2 flash_addr", flash_addr, a[ADDR_W-1:0]);
        host_read(2'd3, s);
        chk("R5 busy status", s, 8'h02);
        poll_done(ok);
        chk("R5 done seen", ok, 1);
        host_read(2'd3, s);
        chk("R5 done status", s, 8'h01);
        host_read(2'd0, v);
        chk("R9 data byte", v, mem_model(a[ADDR_W-1:0]));
        chk("R3 one cycle", ce_falls - f0, 1);
        chk("R4 ce lead", last_lead, 1);
        chk("R4 oe length", last_oe_len, WAIT + 1);
        chk("R4 joint rise", rise_apart, 0);
    endtask

    task automatic t_bad_cmd;
        logic [7:0] s;
        int f0 = ce_falls;
        host_write(2'd3, 8'h02);
        host_write(2'd3, 8'hFE);
        repeat (10) @(negedge clk);
        chk("R3 bad cmd no cycle", ce_falls - f0, 0);
        host_read(2'd3, s);
        chk("R3 status kept", s, 8'h01);
    endtask

    task automatic t_busy;
        logic [23:0] a = 24'h0A_C3_5E;
        logic [23:0] b = 24'h0A_C3_11;
        logic [7:0] s, v;
        bit ok;
        int f0;
        load_addr(a);
        f0 = ce_falls;
        host_write(2'd3, CMD);
        host_write(2'd3, CMD);
        host_write(2'd0, b[7:0]);
        chk("R7 addr held", flash_addr, a[ADDR_W-1:0]);
        poll_done(ok);
        chk("R6 done", ok, 1);
        chk("R6 single cycle", ce_falls - f0, 1);
        host_read(2'd1, v);
        chk("R7 byte from old addr", v, mem_model(a[ADDR_W-1:0]));
        host_write(2'd3, CMD);
        chk("R2 new addr used", flash_addr, b[ADDR_W-1:0]);
        poll_done(ok);
        host_read(2'd2, v);
        chk("R2 new byte", v, mem_model(b[ADDR_W-1:0]));
        host_read(2'd3, s);
        chk("R5 status after", s, 8'h01);
    endtask

    task automatic t_long_strobe;
        bit ok;
        int f0 = ce_falls;
        host_write(2'd3, CMD, 120);
        poll_done(ok);
        chk("R10 held strobe one cycle", ce_falls - f0, 1);
        chk("R9 bus z", host_data, 8'bz);
        chk("R8 we_n never low", we_seen_low, 0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic(24'hF7_34_12);
        t_basic(24'h03_A9_C0);
        t_bad_cmd();
        t_busy();
        t_long_strobe();
        finish_run();
    end
endmodule